// File: doc/BRIEF.md
# Permuted Line-Buffer Address Generator

This block produces the location sequence for a single-line video buffer that is read and then written at the same location in the same pixel slot. The pixels of each line land in the order the block generates. The same walk, taken on the next line with a new stride, reads them back so that the two halves of the previous line come out interleaved. One line of storage therefore covers both the reordering and the one-line delay, and the addressing needs no second pointer.

A line is opened with `line_start`, which also samples the programmable `line_len`. Each `advance` then moves to the next pixel slot. With limit `L = line_len - 1`, slot 0 is location 0. Every later slot, except the last, adds the line's stride and folds the sum back by subtracting `L` once when the sum is greater than `L`. The last slot always addresses `L` and raises `line_done`. At the middle slot the newly computed address becomes the stride for the following line. The wrap decision uses two adders working in parallel and one comparison against a constant prepared at line start, so the carry path stays short.

Top module: `permline_addr_gen`

## Requirements
- R1: After reset, `addr_o` is 0 and `line_done` is low.
- R2: The first line after reset, and the first line after a length change, uses stride 1, giving locations 0,1,2,...,L in order.
- R3: After `line_start`, slot 0 is location 0. On each `advance` before the last slot, the next location is (location + stride), reduced by L once if the sum exceeds L. L is `line_len - 1`.
- R4: The stride of a line equals the location issued at slot (L>>1)+1 of the previous line of the same length. Equivalently, slot 1 of a line repeats that location.
- R5: The last slot (index L) always issues location L, with `line_done` high. `line_done` is high on no other cycle, and an `advance` there ends the line.
- R6: For a 12-pixel line, the second line after reset issues 0 6 1 7 2 8 3 9 4 10 5 11. The eleventh line is back in natural order.
- R7: `line_len` is sampled only at `line_start`. A value that differs from the previous line's length forces the stride back to 1.
- R8: While `advance` and `line_start` are low, `addr_o` and `line_done` hold their values.
- R9: `line_start` in the middle of a line restarts at slot 0, location 0, and takes priority over `advance`.
- R10: Any even line length from 2 to `DEPTH` is supported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Opens a new line and samples `line_len` |
| advance | input | 1 | Moves to the next pixel slot |
| line_len | input | $clog2(DEPTH+1) | Pixels per line (even, 2..DEPTH) |
| addr_o | output | $clog2(DEPTH) | Buffer location for the current slot |
| line_done | output | 1 | High while the final slot is issued |

## Verification
The bench first runs back-to-back lines of 12 pixels. This pattern is the one whose second-line order and return to natural order after ten lines are known, so it separates a correct fold by L from a fold by the full length, and a correct middle capture from an off-by-one slot. It then changes the length to 20 and to 64. These runs show whether the stride is reset on a length change and whether wide strides wrap correctly. Random gaps in `advance` test that idle cycles freeze the walk. A restart midway through a 64-pixel line tests that `line_start` takes priority and that the stride captured earlier in the line survives.

// File: rtl/permline_addr_gen.sv
module permline_addr_gen #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          advance,
  input  logic [LW-1:0] line_len,
  output logic [AW-1:0] addr_o,
  output logic          line_done
);

  logic [LW-1:0] len_q;
  logic [AW-1:0] lim, stride, next_stride, thr, sdiff;
  logic [AW-1:0] addr_q, cnt;
  logic          active;

  logic          same_len;
  logic [AW-1:0] lim_n, st0, nxt;
  logic          last;

  assign same_len = (line_len == len_q);
  assign lim_n    = AW'(line_len - LW'(1));
  assign st0      = same_len ? next_stride : AW'(1);
  assign nxt      = (addr_q > thr) ? addr_q + sdiff : addr_q + stride;
  assign last     = (cnt == lim);

  assign addr_o    = last ? lim : addr_q;
  assign line_done = active && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q       <= '0;
      lim         <= '0;
      stride      <= AW'(1);
      next_stride <= AW'(1);
      thr         <= '0;
      sdiff       <= '0;
      addr_q      <= '0;
      cnt         <= '0;
      active      <= 1'b0;
    end else if (line_start) begin
      len_q  <= line_len;
      lim    <= lim_n;
      stride <= st0;
      thr    <= lim_n - st0;
      sdiff  <= st0 - lim_n;
      addr_q <= '0;
      cnt    <= '0;
      active <= 1'b1;
      if (!same_len) next_stride <= AW'(1);
    end else if (active && advance) begin
      if (last) begin
        active <= 1'b0;
      end else begin
        addr_q <= nxt;
        cnt    <= cnt + AW'(1);
        if (cnt == (lim >> 1)) next_stride <= nxt;
      end
    end
  end

endmodule

// File: rtl/permline_addr_chk.sv
module permline_addr_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_start,
  input logic          advance,
  input logic [AW-1:0] addr_o,
  input logic          line_done,
  input logic          active,
  input logic [AW-1:0] lim
);

  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (addr_o == '0)) else $error("start not at zero"); // R3

  AST_START_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_done) else $error("done at slot zero"); // R9

  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (addr_o <= lim)) else $error("address beyond limit"); // R3

  AST_DONE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> (addr_o == lim)) else $error("done off limit"); // R5

  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && advance && !line_start) |=> !line_done) else $error("done lingers"); // R5

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !line_start) |=> ($stable(addr_o) && $stable(line_done))) else $error("moved while idle"); // R8

endmodule

bind permline_addr_gen permline_addr_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .advance(advance),
  .addr_o(addr_o), .line_done(line_done), .active(active), .lim(lim)
);

// File: tb/sim_permline_addr_gen.sv
module sim_permline_addr_gen;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, line_start = 0, advance = 0;
  logic [LW-1:0] line_len = '0;
  logic [AW-1:0] addr_o;
  logic line_done;

  permline_addr_gen #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .advance(advance),
    .line_len(line_len), .addr_o(addr_o), .line_done(line_done)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int lst [0:63];
  int act [0:63];
  int prv [0:63];
  int idx, mlen, prevlen = 0, newincr = 1;
  bit mact = 0;

  task automatic chk(input bit ok, input string tag, input int a, input int e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, a, e);
    end
  endtask

  task automatic build(input int len);
    int L, M, a, incr;
    L = len - 1; M = L >> 1;
    incr = (len != prevlen) ? 1 : newincr;
    prevlen = len; a = 0;
    for (int c = 0; c < L; c++) begin
      lst[c] = a;
      a += incr;
      if (a > L) a -= L;
      if (c == M) newincr = a;
    end
    lst[L] = L;
  endtask

  task automatic compare();
    if (mact) begin
      act[idx] = int'(addr_o);
      chk(int'(addr_o) == lst[idx], "R3 address", int'(addr_o), lst[idx]);
      chk(line_done == (idx == mlen - 1), "R5 line_done", int'(line_done), int'(idx == mlen - 1));
    end else begin
      chk(line_done == 0, "R5 idle done", int'(line_done), 0);
    end
  endtask

  task automatic run_line(input int len, input int gap, input int stop_at);
    bit a;
    for (int i = 0; i < 64; i++) prv[i] = act[i];
    @(negedge clk);
    compare();
    line_start = 1; line_len = LW'(len); advance = 0;
    build(len); mlen = len; idx = 0; mact = 1;
    forever begin
      @(negedge clk);
      line_start = 0;
      compare();
      if (!mact) break;
      if (stop_at >= 0 && idx == stop_at) begin advance = 0; return; end
      a = ($urandom % 100) >= gap;
      advance = a;
      if (a) begin
        if (idx == mlen - 1) mact = 0; else idx++;
      end
    end
    advance = 0;
  endtask

  initial begin
    int lim;
    repeat (10000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int sec [0:11];
    sec = '{0, 6, 1, 7, 2, 8, 3, 9, 4, 10, 5, 11};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(addr_o == 0, "R1 reset addr", int'(addr_o), 0);
    chk(line_done == 0, "R1 reset done", int'(line_done), 0);
    rst_n = 1;

    run_line(12, 0, -1);
    for (int i = 0; i < 12; i++) chk(act[i] == i, "R2 natural first line", act[i], i);
    run_line(12, 0, -1);
    for (int i = 0; i < 12; i++) chk(act[i] == sec[i], "R6 second line", act[i], sec[i]);
    chk(act[1] == prv[6], "R4 stride capture", act[1], prv[6]);
    for (int n = 3; n <= 10; n++) run_line(12, 30, -1);
    run_line(12, 0, -1);
    for (int i = 0; i < 12; i++) chk(act[i] == i, "R6 period return", act[i], i);

    run_line(20, 20, -1);
    for (int i = 0; i < 20; i++) chk(act[i] == i, "R7 new length natural", act[i], i);
    run_line(20, 40, -1);
    chk(act[1] == prv[10], "R4 stride capture len20", act[1], prv[10]);
    run_line(20, 0, -1);

    run_line(64, 25, -1);
    run_line(64, 0, -1);
    chk(act[1] == prv[32], "R10 full depth capture", act[1], prv[32]);
    run_line(64, 10, 40);
    run_line(64, 0, -1);
    chk(act[0] == 0, "R9 restart at zero", act[0], 0);
    run_line(64, 50, -1);
    run_line(2, 0, -1);
    chk(act[0] == 0 && act[1] == 1, "R10 minimum length", act[1], 1);

    repeat (2) @(negedge clk);
    chk(line_done == 0, "R8 idle hold", int'(line_done), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule